// File: doc/BRIEF.md
# Triggered Scanline Pixel Streamer

This block drives the pixel bus of a raster display during the visible part of each scanline. It sits idle, showing a black (all-zero) pixel, until a line-start pulse arrives from the sync-timing logic. After a fixed start latency it pulls 32-bit words from an upstream FIFO over a valid/ready handshake. It splits each word into two 16-bit pixels and holds each pixel on the output for a fixed number of system clocks. With the defaults, 320 pixels are each held for 10 clocks. At a 125 MHz system clock this shows every logical pixel twice at a 25 MHz dot rate.

Each pixel carries 15 bits of colour, 5 bits each for red, green and blue. Bit 15 of every pixel is dropped. When the line is done the output returns to zero and stays there until the next accepted trigger. Two sticky flags report faults. One records a trigger that arrived while a line was still in progress; such a trigger is otherwise ignored. The other records a word that was needed while the FIFO had nothing to offer; the two pixels of that word are shown as zero and the line timing does not slip.

Top module: `scanline_streamer`

## Requirements
- R1: After reset, `pix_out` is 0, `in_ready` is 0, and `retrig_err` and `underrun_err` are 0.
- R2: A trigger is accepted when `line_start` is high at a clock edge while the block is idle. The first pixel of the line appears on `pix_out` exactly START_DELAY (7) clock edges after that edge. Until then, `pix_out` stays 0.
- R3: Each pixel stays unchanged on `pix_out` for exactly HOLD (10) clocks.
- R4: One line shows PIXELS (320) pixels in consecutive hold slots, built from PIXELS/2 (160) input words.
- R5: Within a word, bits [15:0] form the earlier pixel and bits [31:16] the later pixel.
- R6: `pix_out[15]` is always 0. `pix_out[14:0]` equals bits [14:0] of the pixel's 16-bit half-word.
- R7: A word is consumed only in a cycle where `in_ready` and `in_valid` are both high. `in_ready` rises once per word: at the last clock before the pixel slot that needs the word, and only after both halves of the previous word have been shown.
- R8: From the edge that ends the last pixel's hold slot, `pix_out` is 0 until the next accepted trigger.
- R9: A trigger while a line is waiting or streaming has no effect on the line's timing or pixels. It sets `retrig_err`, which stays high until reset.
- R10: If `in_valid` is low when a word is needed, both pixels of that word are shown as 0 and the line timing is unchanged. `underrun_err` is set and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Line-start trigger from the sync timing logic |
| in_data | input | 32 | Word holding two packed pixels |
| in_valid | input | 1 | `in_data` holds a word |
| in_ready | output | 1 | Block takes the word this cycle |
| pix_out | output | 16 | Pixel bus, 5:5:5 RGB in bits [14:0], bit 15 zero |
| retrig_err | output | 1 | Sticky: trigger seen while busy |
| underrun_err | output | 1 | Sticky: word needed while none was offered |

## Verification
The hardest state to reach from the ports is a trigger that lands in the middle of a streaming line. It must leave the pixel sequence and the word count untouched while raising its flag. The bench injects such a pulse inside one line's hold slot and keeps checking every following pixel and the running word count against its own model. Random pixel words are drawn from a seeded generator, and each slot is compared with the half-word the model predicts. The underrun is reached by withholding `in_valid` for a whole line. That line must then be entirely black with its timing unchanged.

// File: rtl/scanline_streamer.sv
module scanline_streamer #(
  parameter int PIXELS      = 320,
  parameter int HOLD        = 10,
  parameter int START_DELAY = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_start,
  input  logic [31:0] in_data,
  input  logic        in_valid,
  output logic        in_ready,
  output logic [15:0] pix_out,
  output logic        retrig_err,
  output logic        underrun_err
);
  localparam int IDX_W  = $clog2(PIXELS);
  localparam int HOLD_W = $clog2(HOLD + 1);
  localparam int DLY_W  = $clog2(START_DELAY + 1);
  localparam logic [1:0] S_IDLE = 2'd0, S_WAIT = 2'd1, S_RUN = 2'd2;

  logic [1:0]        state;
  logic [DLY_W-1:0]  dly;
  logic [HOLD_W-1:0] hold;
  logic [IDX_W-1:0]  idx;
  logic [14:0]       upper;

  wire slot_end = (hold == '0);
  wire last_pix = (idx == IDX_W'(PIXELS - 1));
  wire fetch    = (state == S_WAIT && dly == '0) ||
                  (state == S_RUN && slot_end && !last_pix && idx[0]);
  wire [15:0] low_pix = in_valid ? {1'b0, in_data[14:0]} : 16'h0;
  wire [14:0] hi_keep = in_valid ? in_data[30:16] : 15'h0;

  assign in_ready = fetch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      dly          <= '0;
      hold         <= '0;
      idx          <= '0;
      upper        <= '0;
      pix_out      <= '0;
      retrig_err   <= 1'b0;
      underrun_err <= 1'b0;
    end else begin
      if (line_start && state != S_IDLE) retrig_err <= 1'b1;
      if (fetch && !in_valid) underrun_err <= 1'b1;
      case (state)
        S_IDLE: if (line_start) begin
          state <= S_WAIT;
          dly   <= DLY_W'(START_DELAY - 1);
        end
        S_WAIT: if (dly != '0) begin
          dly <= dly - 1'b1;
        end else begin
          state   <= S_RUN;
          idx     <= '0;
          hold    <= HOLD_W'(HOLD - 1);
          pix_out <= low_pix;
          upper   <= hi_keep;
        end
        S_RUN: if (!slot_end) begin
          hold <= hold - 1'b1;
        end else if (last_pix) begin
          state   <= S_IDLE;
          pix_out <= '0;
        end else begin
          idx  <= idx + 1'b1;
          hold <= HOLD_W'(HOLD - 1);
          if (idx[0]) begin
            pix_out <= low_pix;
            upper   <= hi_keep;
          end else begin
            pix_out <= {1'b0, upper};
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scanline_streamer_checks.sv
module scanline_streamer_checks #(
  parameter int HOLD_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_start,
  input logic              in_ready,
  input logic [15:0]       pix_out,
  input logic              retrig_err,
  input logic              underrun_err,
  input logic [1:0]        state,
  input logic [HOLD_W-1:0] hold
);
  a_r6_msb_clear: assert property (@(posedge clk) disable iff (!rst_n)
    pix_out[15] == 1'b0);

  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd2 && hold != '0) |=> $stable(pix_out));

  a_r8_idle_black: assert property (@(posedge clk) disable iff (!rst_n)
    (state != 2'd2) |-> pix_out == 16'h0);

  a_r9_retrig_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    retrig_err |=> retrig_err);

  a_r10_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_err |=> underrun_err);

  a_r2_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0 && line_start) |=> state == 2'd1);

  a_r7_no_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0) |-> !in_ready);
endmodule

bind scanline_streamer scanline_streamer_checks #(.HOLD_W(HOLD_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .in_ready(in_ready),
  .pix_out(pix_out), .retrig_err(retrig_err), .underrun_err(underrun_err),
  .state(state), .hold(hold)
);

// File: tb/scanline_streamer_bench.sv
module scanline_streamer_bench;
  localparam int CLK_PERIOD = 8;
  localparam int PIXELS = 320;
  localparam int HOLD = 10;
  localparam int DLY = 7;
  localparam int WORDS = PIXELS / 2;

  logic clk = 0, rst_n = 0, line_start = 0;
  logic [31:0] in_data;
  logic in_valid, in_ready;
  logic [15:0] pix_out;
  logic retrig_err, underrun_err;

  logic [31:0] words [WORDS];
  int ptr = 0;
  int cyc = 0;
  bit feed_en = 0;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign in_valid = feed_en && ptr < WORDS;
  assign in_data  = (ptr < WORDS) ? words[ptr] : 32'h0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (in_valid && in_ready) ptr <= ptr + 1;
  end

  scanline_streamer #(.PIXELS(PIXELS), .HOLD(HOLD), .START_DELAY(DLY)) u_scanline_streamer (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .pix_out(pix_out),
    .retrig_err(retrig_err), .underrun_err(underrun_err)
  );

  function automatic logic [15:0] exp_pix(logic [31:0] w, int half);
    return half ? {1'b0, w[30:16]} : {1'b0, w[14:0]};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic wait_edge(int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic run_line(bit feed, int retrig_at);
    int tk;
    for (int i = 0; i < WORDS; i++) words[i] = $urandom;
    words[0][15] = 1'b1;
    words[0][31] = 1'b1;
    ptr = 0;
    feed_en = feed;
    @(negedge clk);
    line_start = 1;
    @(negedge clk);
    line_start = 0;
    tk = cyc;
    wait_edge(tk + DLY - 1);
    check(pix_out == 16'h0, "R2 black before first pixel", pix_out, 0);
    for (int p = 0; p < PIXELS; p++) begin
      wait_edge(tk + DLY + p * HOLD + HOLD / 2);
      if (feed) begin
        check(pix_out == exp_pix(words[p/2], p % 2), "R4 R5 R6 pixel value",
              pix_out, exp_pix(words[p/2], p % 2));
        check(ptr == p / 2 + 1, "R7 words consumed", ptr, p / 2 + 1);
      end else begin
        check(pix_out == 16'h0, "R10 underrun pixel black", pix_out, 0);
      end
      if (p == retrig_at) begin
        line_start = 1;
        @(negedge clk);
        line_start = 0;
        @(negedge clk);
        check(retrig_err == 1'b1, "R9 retrigger flagged", retrig_err, 1);
      end
    end
    wait_edge(tk + DLY + PIXELS * HOLD - 1);
    check(pix_out == (feed ? exp_pix(words[WORDS-1], 1) : 16'h0),
          "R3 last slot still held", pix_out, feed ? exp_pix(words[WORDS-1], 1) : 0);
    wait_edge(tk + DLY + PIXELS * HOLD);
    check(pix_out == 16'h0, "R8 black after line", pix_out, 0);
    if (feed) check(ptr == WORDS, "R4 word count per line", ptr, WORDS);
    repeat (30) @(negedge clk);
    check(pix_out == 16'h0, "R8 black stays until trigger", pix_out, 0);
    check(in_ready == 1'b0, "R7 no request when idle", in_ready, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(pix_out == 16'h0, "R1 reset pixel", pix_out, 0);
    check(in_ready == 1'b0, "R1 reset ready", in_ready, 0);
    check(retrig_err == 1'b0 && underrun_err == 1'b0, "R1 reset flags",
          {retrig_err, underrun_err}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run_line(1, -1);
    check(retrig_err == 1'b0, "R9 no spurious flag", retrig_err, 0);
    check(underrun_err == 1'b0, "R10 no spurious flag", underrun_err, 0);
    run_line(1, 57);
    run_line(1, -1);
    check(retrig_err == 1'b1, "R9 flag sticky", retrig_err, 1);
    check(underrun_err == 1'b0, "R10 still clear with data", underrun_err, 0);
    run_line(0, -1);
    check(underrun_err == 1'b1, "R10 underrun flagged", underrun_err, 1);
    run_line(1, -1);
    check(underrun_err == 1'b1, "R10 flag sticky", underrun_err, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule